// File: doc/BRIEF.md
# Free-Running Rotating Serial Output Unit

This block is the serial shift section of a peripheral interface adapter, built only for its free-running output mode. Once software writes the mode value into the shift-control field of the auxiliary control register, an 8-bit pattern register starts to rotate. Each shift event places one bit on the CB2 line. The same bit goes back into the other end of the register, so the stored byte is never consumed and the bit sequence repeats without end.

Shift events come from a down-counting divider. It reloads by itself from a timer byte that software writes. A reload value of N gives one bit every N clock cycles. The value 0 stands for 256. With N = 1 and the pattern 10101010, CB2 carries a square wave at half the clock rate.

While the mode is active, the block takes CB2 away from the control-line logic and raises a flag that says so. It also gives a one-cycle shift strobe on CB1 each time a new bit appears. Software can rewrite the pattern at any time without stopping the output. The new byte starts at the next bit boundary.

Top module: `rot_shift_unit`

## Requirements
- R1: Synchronous active-low reset. After reset, cb2_own and cb1_out are 0 and cb2_out equals pcr_cb2_level. The pattern register, the control register and the timer byte are all 0, so a later mode entry with no other writes shifts out zeros every 256 cycles.
- R2: A write to offset 0xB with bits 4..2 equal to binary 100 turns the rotating mode on, and cb2_own is 1 from the clock after that write. A write to offset 0xB with any other value in bits 4..2 turns the mode off, and cb2_own is 0 from the clock after that write.
- R3: The timer byte is written at offset 0x8. While the mode is on, a shift event occurs every N clocks, where N is the timer byte and N = 0 means 256. The first event comes N clocks after the clock edge that turns the mode on.
- R4: Bits leave the pattern most significant bit first. The k-th shift event after a pattern load (k counted from 0) drives bit 7-(k mod 8) of that pattern onto cb2_out. Between events, cb2_out holds the last bit shifted out, which is 0 if no bit has been shifted out since reset.
- R5: Rotation does not destroy the pattern. With no new write, the 8-bit sequence on cb2_out repeats without end.
- R6: While cb2_own is 1, pcr_cb2_level has no effect on cb2_out. While cb2_own is 0, cb2_out equals pcr_cb2_level.
- R7: cb1_out is 1 for exactly the one clock in which a newly shifted bit first appears on cb2_out. It is 0 in every other clock and whenever the mode is off.
- R8: A write to offset 0xA replaces the pattern and does not pause the divider. The next shift event outputs bit 7 of the new byte, even when that event falls on the same clock as the write.
- R9: A timer byte written while the mode is on leaves the interval in progress unchanged. The new value applies from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset (0x8 timer byte, 0xA pattern, 0xB control) |
| wr_data | input | 8 | Write data |
| pcr_cb2_level | input | 1 | CB2 level requested by the control-line logic |
| cb2_out | output | 1 | Value driven onto CB2 |
| cb2_own | output | 1 | High while the shifter overrides CB2 |
| cb1_out | output | 1 | Shift strobe, one clock per new bit |

## Verification
The checker watches several properties on every clock. Mode entry and exit must follow control-register writes one clock later. CB2 may change under ownership only on a strobe clock, and CB1 may pulse only while the mode is on. The number of ones in the pattern must stay the same through each rotation, and a pattern write must land intact. The bench scenarios are needed for the rest: the exact bit order and its eight-bit repeat, the interval length for each timer value including the 256-cycle case, the deferred effect of a timer write made mid-interval, and a pattern write that collides with a shift event.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets and field positions for the rotating shift unit.
// Assumes an 8-bit register interface with 4-bit offsets.
package rsu_pkg;
    localparam int unsigned RSU_DATA_W = 8;
    localparam int unsigned RSU_ADDR_W = 4;

    // Register offsets
    localparam logic [RSU_ADDR_W-1:0] OFF_T2LO = 4'h8;
    localparam logic [RSU_ADDR_W-1:0] OFF_PAT  = 4'hA;
    localparam logic [RSU_ADDR_W-1:0] OFF_CTRL = 4'hB;

    // Shift-control field inside the control register
    localparam int unsigned MODE_LSB = 2;
    localparam int unsigned MODE_W   = 3;
    localparam logic [MODE_W-1:0] MODE_FREE_ROT = 3'b100;
endpackage

// File: rtl/rsu_regs.sv
`timescale 1ns/1ps
// Module: rsu_regs
// Holds the control register and the timer reload byte, and decodes
// pattern writes for the rotator. Assumes writes are single-cycle strobes.
module rsu_regs
    import rsu_pkg::*;
#(
    parameter int unsigned DATA_W = RSU_DATA_W,
    parameter int unsigned ADDR_W = RSU_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run,
    output logic [DATA_W-1:0] reload,
    output logic              pat_wr,
    output logic [DATA_W-1:0] pat_wdata
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] t2lo_q;

    // Capture control register and timer byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            t2lo_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFF_CTRL) ctrl_q <= wr_data;
            if (wr_addr == OFF_T2LO) t2lo_q <= wr_data;
        end
    end

    // Decode mode and pattern-write strobe
    always_comb begin
        run       = (ctrl_q[MODE_LSB +: MODE_W] == MODE_FREE_ROT);
        reload    = t2lo_q;
        pat_wr    = wr_en && (wr_addr == OFF_PAT);
        pat_wdata = wr_data;
    end
endmodule

// File: rtl/rsu_divider.sv
`timescale 1ns/1ps
// Module: rsu_divider
// Auto-reloading down-counter that emits one tick every 'reload' cycles
// while running (reload 0 acts as 2**CNT_W). Held at the reload value when
// idle, so a fresh interval starts on mode entry.
module rsu_divider #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    // Tick when the count reaches one while running
    always_comb tick = run && (cnt_q == CNT_W'(1));

    // Count down, reload on tick, track reload when idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= reload;
        else
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/rsu_rotator.sv
`timescale 1ns/1ps
// Module: rsu_rotator
// Pattern register that rotates left by one on each tick, presenting the
// departing MSB as the output bit. A pattern write in the tick cycle is
// used as the source, so the new byte starts at that boundary.
module rsu_rotator #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pat_wr,
    input  logic [DATA_W-1:0] pat_wdata,
    output logic [DATA_W-1:0] pat_q,
    output logic              bit_q,
    output logic              strobe_q
);
    logic [DATA_W-1:0] src;

    // Select the freshly written byte over the stored one
    always_comb src = pat_wr ? pat_wdata : pat_q;

    // Rotate on tick, load on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            pat_q <= '0;
        else if (tick)
            pat_q <= {src[DATA_W-2:0], src[DATA_W-1]};
        else if (pat_wr)
            pat_q <= src;
    end

    // Register the departing bit and the strobe marking its arrival
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            if (tick) bit_q <= src[DATA_W-1];
            strobe_q <= tick;
        end
    end
endmodule

// File: rtl/rot_shift_unit.sv
`timescale 1ns/1ps
// Module: rot_shift_unit (top)
// Free-running rotating serial output: takes over CB2 while the mode is
// selected, shifts the pattern MSB first at the divider rate, and strobes
// CB1 per bit. Assumes the control-line block honours cb2_own.
module rot_shift_unit
    import rsu_pkg::*;
#(
    parameter int unsigned DATA_W = RSU_DATA_W,
    parameter int unsigned ADDR_W = RSU_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pcr_cb2_level,
    output logic              cb2_out,
    output logic              cb2_own,
    output logic              cb1_out
);
    logic              run;
    logic [DATA_W-1:0] reload;
    logic              pat_wr;
    logic [DATA_W-1:0] pat_wdata;
    logic              tick;
    logic [DATA_W-1:0] pat_val;
    logic              bit_q;
    logic              strobe_q;

    rsu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .run       (run),
        .reload    (reload),
        .pat_wr    (pat_wr),
        .pat_wdata (pat_wdata)
    );

    rsu_divider #(.CNT_W(DATA_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (reload),
        .tick   (tick)
    );

    rsu_rotator #(.DATA_W(DATA_W)) u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pat_wr    (pat_wr),
        .pat_wdata (pat_wdata),
        .pat_q     (pat_val),
        .bit_q     (bit_q),
        .strobe_q  (strobe_q)
    );

    // Drive CB2 from the shifter while owned, else pass the control level
    always_comb begin
        cb2_own = run;
        cb2_out = run ? bit_q : pcr_cb2_level;
        cb1_out = strobe_q && run;
    end
endmodule

// File: rtl/rot_shift_unit_chk.sv
`timescale 1ns/1ps
// Module: rot_shift_unit_chk
// Cycle-by-cycle properties for rot_shift_unit, attached by bind.
module rot_shift_unit_chk
    import rsu_pkg::*;
#(
    parameter int unsigned DATA_W = RSU_DATA_W,
    parameter int unsigned ADDR_W = RSU_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              cb2_own,
    input logic              cb2_out,
    input logic              cb1_out,
    input logic              tick,
    input logic              pat_wr,
    input logic [DATA_W-1:0] pat_val
);
    // R2
    mode_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_CTRL && wr_data[MODE_LSB +: MODE_W] == MODE_FREE_ROT) |=> cb2_own);

    // R2
    mode_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_CTRL && wr_data[MODE_LSB +: MODE_W] != MODE_FREE_ROT) |=> !cb2_own);

    // R7
    strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cb1_out |-> cb2_own);

    // R4
    cb2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cb2_own && $past(cb2_own) && !cb1_out) |-> $stable(cb2_out));

    // R5
    rotate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pat_wr) |=> ($countones(pat_val) == $countones($past(pat_val))));

    // R8
    pat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_wr && !tick) |=> (pat_val == $past(wr_data)));
endmodule

bind rot_shift_unit rot_shift_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cb2_own (cb2_own),
    .cb2_out (cb2_out),
    .cb1_out (cb1_out),
    .tick    (tick),
    .pat_wr  (pat_wr),
    .pat_val (pat_val)
);

// File: tb/rot_shift_unit_tb.sv
`timescale 1ns/1ps
// Bench for rot_shift_unit: directed corners plus seeded random runs,
// compared each cycle against a requirement-level expectation.
module rot_shift_unit_tb;
    localparam logic [3:0] A_T2  = 4'h8;
    localparam logic [3:0] A_PAT = 4'hA;
    localparam logic [3:0] A_CTL = 4'hB;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       pcr_lvl;
    logic       cb2_out;
    logic       cb2_own;
    logic       cb1_out;

    int checks = 0;
    int fails  = 0;
    string req = "R1";

    // Expectation state
    bit       m_run;
    int       m_latch;
    int       m_left;
    bit [7:0] m_pat;
    int       m_idx;
    bit       m_bit;

    always #2.5 clk = ~clk;

    rot_shift_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .pcr_cb2_level (pcr_lvl),
        .cb2_out       (cb2_out),
        .cb2_own       (cb2_own),
        .cb1_out       (cb1_out)
    );

    function automatic int interval(int n);
        return (n == 0) ? 256 : n;
    endfunction

    function automatic bit [7:0] ctl_off_value();
        bit [7:0] v = 8'($urandom);
        bit [2:0] f = 3'($urandom % 7);
        if (f >= 3'd4) f = f + 3'd1;
        v[4:2] = f;
        return v;
    endfunction

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One clock with an optional write, then compare all outputs
    task automatic step(bit w, logic [3:0] a, logic [7:0] d, bit rnd_pcr);
        bit evt = 1'b0;
        if (rnd_pcr) pcr_lvl = 1'($urandom);
        wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (w && a == A_PAT) begin m_pat = d; m_idx = 0; end
        if (m_run) begin
            m_left--;
            if (m_left == 0) begin
                evt    = 1'b1;
                m_bit  = m_pat[7 - (m_idx % 8)];
                m_idx++;
                m_left = interval(m_latch);
            end
        end else begin
            m_left = interval(m_latch);
        end
        if (w && a == A_T2) m_latch = int'(d);
        if (w && a == A_CTL) m_run = (d[4:2] == 3'b100);
        #1;
        wr_en = 1'b0;
        chk("cb2_own", cb2_own, m_run);
        chk("cb1_out", cb1_out, evt && m_run);
        chk("cb2_out", cb2_out, m_run ? m_bit : pcr_lvl);
    endtask

    task automatic idle(int n, bit rnd_pcr);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, rnd_pcr);
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pcr_lvl = 1'b1;
        m_run = 0; m_latch = 0; m_left = 256; m_pat = '0; m_idx = 0; m_bit = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        req = "R1";
        chk("cb2_own", cb2_own, 1'b0);
        chk("cb1_out", cb1_out, 1'b0);
        chk("cb2_out", cb2_out, 1'b1);
        pcr_lvl = 1'b0; #1;
        chk("cb2_out", cb2_out, 1'b0);
        rst_n = 1'b1;

        // R1, R3: reset defaults give zeros every 256 cycles
        req = "R3";
        step(1'b1, A_CTL, 8'b0001_0000, 1'b0);
        idle(520, 1'b1);
        step(1'b1, A_CTL, 8'h00, 1'b0);
        idle(3, 1'b1);

        // R4, R5, R6: N = 1, pattern 10101010 gives a square wave at half clock
        req = "R5";
        step(1'b1, A_T2, 8'd1, 1'b0);
        step(1'b1, A_PAT, 8'hAA, 1'b0);
        step(1'b1, A_CTL, 8'h10, 1'b0);
        idle(40, 1'b1);

        // R9: timer byte change mid-run applies after current interval
        req = "R9";
        step(1'b1, A_T2, 8'd2, 1'b0);
        idle(7, 1'b0);
        step(1'b1, A_T2, 8'd5, 1'b0);
        idle(30, 1'b1);

        // R8: pattern writes at each phase of an interval, including the tick cycle
        req = "R8";
        step(1'b1, A_T2, 8'd3, 1'b0);
        idle(6, 1'b0);
        for (int ph = 0; ph < 3; ph++) begin
            step(1'b1, A_PAT, 8'($urandom), 1'b1);
            idle(10 + ph, 1'b1);
        end
        step(1'b1, A_T2, 8'd1, 1'b0);
        idle(4, 1'b0);
        step(1'b1, A_PAT, 8'h0F, 1'b0);
        idle(12, 1'b1);

        // R2: leave with a non-matching field, CB2 returns to control level
        req = "R2";
        step(1'b1, A_CTL, ctl_off_value(), 1'b0);
        idle(5, 1'b1);

        // R4, R6, R7, R8: seeded random runs
        for (int it = 0; it < 14; it++) begin
            int n = 1 + int'($urandom % 6);
            req = "R4";
            step(1'b1, A_T2, 8'(n), 1'b0);
            step(1'b1, A_PAT, 8'($urandom), 1'b0);
            step(1'b1, A_CTL, 8'($urandom) | 8'h10 & 8'hF3 | 8'h10, 1'b0);
            for (int c = 0; c < 18 * n; c++) begin
                req = "R7";
                if (($urandom % 24) == 0) begin
                    req = "R8";
                    step(1'b1, A_PAT, 8'($urandom), 1'b1);
                end else begin
                    step(1'b0, 4'h0, 8'h00, 1'b1);
                end
            end
            req = "R2";
            step(1'b1, A_CTL, ctl_off_value(), 1'b0);
            req = "R6";
            idle(4, 1'b1);
        end

        report();
        $finish;
    end
endmodule